// File: doc/BRIEF.md
# Bit-Serial Column-Parallel Add/Subtract Engine

This block models a storage array laid out as rows of `LANES` bits. Each column is a lane that holds one word. A multi-bit operand is stored bit-sliced: bit i of every lane's operand sits in row `base + i`. A single command adds or subtracts two such operands in every lane at once. The engine walks the bit positions from the least significant upward. For each position it spends one cycle sensing the two operand rows and a hidden carry/borrow row through one full adder or full subtractor per lane. It spends a second cycle writing the sum or difference bit and the new carry or borrow back into the array.

The carry or borrow is kept in a dedicated array row rather than in a flip-flop per lane, so an n-bit operation always costs 2n cycles no matter how many lanes there are. The result occupies rows `r_base` to `r_base + n`, and the top row receives the final carry or borrow. When the engine is idle, a plain single-port read/write interface gives access to every visible row, so the operands can be loaded and the results fetched. Row addresses wrap modulo `ROWS`.

Top module: `bsa_engine`

## Requirements
- R1: With `op_sub` = 0, once the engine is idle again, row `r_base+i` (for i < n) holds bit i of A+B in each lane, and row `r_base+n` holds the carry out, so that rows `r_base` to `r_base+n` read as (A+B) mod 2^(n+1).
- R2: With `op_sub` = 1, rows `r_base` to `r_base+n` read as (A−B) mod 2^(n+1) in each lane, so the top row is 1 exactly when A < B.
- R3: A start accepted while idle drives `busy` high from the next cycle for exactly 2n cycles, where n is the latched `width`.
- R4: The carry/borrow row is cleared to 0 when a command is accepted, so a carry left over from an earlier command never enters bit 0 of a new one.
- R5: When idle, `mem_en`=1 with `mem_we`=1 writes `mem_wdata` to row `mem_addr`. With `mem_we`=0 it reads that row onto `mem_rdata` one cycle later. `mem_rdata` is 0 after reset.
- R6: Memory-port writes and reads issued while `busy` is high have no effect: array contents and `mem_rdata` are unchanged.
- R7: A `start` pulse while `busy` is high is ignored. The running command finishes with its own width, operation and rows.
- R8: A `start` with `width` of 0 or larger than `WMAX` is ignored, and `busy` stays low.
- R9: All lanes compute at the same time and independently, each from its own column bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken only when idle |
| op_sub | input | 1 | 0 = add, 1 = subtract (A−B) |
| a_base | input | AW | First row of operand A |
| b_base | input | AW | First row of operand B |
| r_base | input | AW | First row of the result |
| width | input | WW | Operand width n, 1..WMAX |
| busy | output | 1 | High while a command runs |
| mem_en | input | 1 | Memory-port access enable |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | AW | Row address for the memory port |
| mem_wdata | input | LANES | Row data to write |
| mem_rdata | output | LANES | Registered row read data |

## Verification
The properties assume that `start` is a single-cycle pulse sampled at a clock edge. They also assume that `width` is valid whenever a command is meant to run. A pulse held across the accepting edge would itself count as a second start while busy. The bench raises `start` for exactly one cycle and drops it before the next edge. It deliberately drives illegal widths and overlapping starts only in the tests aimed at R7 and R8. Operand, result and probe rows are kept apart, because overlapping placements are legal but their outcome is not checked.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SENSE = 2'd1,
    ST_WRITE = 2'd2
  } bsa_state_e;
endpackage

// File: rtl/bsa_lane.sv
module bsa_lane (
  input  logic a_bit,
  input  logic b_bit,
  input  logic c_bit,
  input  logic sub,
  output logic s_bit,
  output logic c_out
);
  logic diff_ab;
  assign diff_ab = a_bit ^ b_bit;
  assign s_bit   = diff_ab ^ c_bit;
  always_comb begin
    if (sub) c_out = (~a_bit & b_bit) | (~diff_ab & c_bit);
    else     c_out = (a_bit & b_bit) | (diff_ab & c_bit);
  end
endmodule

// File: rtl/bsa_array.sv
module bsa_array #(
  parameter int LANES = 8,
  parameter int ROWS  = 32,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [AW-1:0]    host_addr,
  input  logic [LANES-1:0] host_wdata,
  output logic [LANES-1:0] host_rdata,
  input  logic [AW-1:0]    sa_addr,
  input  logic [AW-1:0]    sb_addr,
  output logic [LANES-1:0] sense_a,
  output logic [LANES-1:0] sense_b,
  output logic [LANES-1:0] sense_c,
  input  logic             bit_we,
  input  logic [AW-1:0]    bit_addr,
  input  logic [LANES-1:0] bit_data,
  input  logic             top_we,
  input  logic [AW-1:0]    top_addr,
  input  logic [LANES-1:0] top_data,
  input  logic             cy_clr,
  input  logic             cy_we,
  input  logic [LANES-1:0] cy_data
);
  logic [LANES-1:0] cells [ROWS];
  logic [LANES-1:0] cy_row;

  assign sense_a = cells[sa_addr];
  assign sense_b = cells[sb_addr];
  assign sense_c = cy_row;

  always_ff @(posedge clk) begin
    if (host_we) cells[host_addr] <= host_wdata;
    if (bit_we)  cells[bit_addr]  <= bit_data;
    if (top_we)  cells[top_addr]  <= top_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cy_row <= '0;
    else if (cy_clr) cy_row <= '0;
    else if (cy_we)  cy_row <= cy_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_re) host_rdata <= cells[host_addr];
  end
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq
  import bsa_pkg::*;
#(
  parameter int WMAX = 8,
  parameter int ROWS = 32,
  localparam int AW  = $clog2(ROWS),
  localparam int WW  = $clog2(WMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_sub,
  input  logic [AW-1:0] a_base,
  input  logic [AW-1:0] b_base,
  input  logic [AW-1:0] r_base,
  input  logic [WW-1:0] width,
  output logic          busy,
  output logic          sense_en,
  output logic          write_en,
  output logic          last,
  output logic          cy_clr,
  output logic          op_q,
  output logic [AW-1:0] a_addr,
  output logic [AW-1:0] b_addr,
  output logic [AW-1:0] w_addr,
  output logic [AW-1:0] top_addr
);
  bsa_state_e    state;
  logic [WW-1:0] idx, w_q;
  logic [AW-1:0] a_q, b_q, r_q;
  logic          cmd_ok;

  assign cmd_ok   = start && (state == ST_IDLE) && (width != '0) && (width <= WW'(WMAX));
  assign busy     = (state != ST_IDLE);
  assign sense_en = (state == ST_SENSE);
  assign write_en = (state == ST_WRITE);
  assign cy_clr   = cmd_ok;
  assign last     = (idx == w_q - 1'b1);
  assign a_addr   = a_q + AW'(idx);
  assign b_addr   = b_q + AW'(idx);
  assign w_addr   = r_q + AW'(idx);
  assign top_addr = r_q + AW'(w_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      w_q   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      r_q   <= '0;
      op_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_ok) begin
          state <= ST_SENSE;
          idx   <= '0;
          w_q   <= width;
          a_q   <= a_base;
          b_q   <= b_base;
          r_q   <= r_base;
          op_q  <= op_sub;
        end
        ST_SENSE: state <= ST_WRITE;
        ST_WRITE: begin
          if (last) state <= ST_IDLE;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_SENSE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsa_engine.sv
module bsa_engine #(
  parameter int LANES = 8,
  parameter int ROWS  = 32,
  parameter int WMAX  = 8,
  localparam int AW   = $clog2(ROWS),
  localparam int WW   = $clog2(WMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_sub,
  input  logic [AW-1:0]    a_base,
  input  logic [AW-1:0]    b_base,
  input  logic [AW-1:0]    r_base,
  input  logic [WW-1:0]    width,
  output logic             busy,
  input  logic             mem_en,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_addr,
  input  logic [LANES-1:0] mem_wdata,
  output logic [LANES-1:0] mem_rdata
);
  logic             sense_en, write_en, last, cy_clr, op_q;
  logic [AW-1:0]    a_addr, b_addr, w_addr, top_addr;
  logic [LANES-1:0] sense_a, sense_b, sense_c;
  logic [LANES-1:0] sum_now, cout_now, sum_q, cout_q;
  logic             host_we, host_re;

  assign host_we = mem_en &  mem_we & ~busy;
  assign host_re = mem_en & ~mem_we & ~busy;

  bsa_seq #(.WMAX(WMAX), .ROWS(ROWS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a_base(a_base), .b_base(b_base), .r_base(r_base), .width(width),
    .busy(busy), .sense_en(sense_en), .write_en(write_en), .last(last),
    .cy_clr(cy_clr), .op_q(op_q), .a_addr(a_addr), .b_addr(b_addr),
    .w_addr(w_addr), .top_addr(top_addr)
  );

  bsa_array #(.LANES(LANES), .ROWS(ROWS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_re(host_re), .host_addr(mem_addr),
    .host_wdata(mem_wdata), .host_rdata(mem_rdata),
    .sa_addr(a_addr), .sb_addr(b_addr),
    .sense_a(sense_a), .sense_b(sense_b), .sense_c(sense_c),
    .bit_we(write_en), .bit_addr(w_addr), .bit_data(sum_q),
    .top_we(write_en & last), .top_addr(top_addr), .top_data(cout_q),
    .cy_clr(cy_clr), .cy_we(write_en), .cy_data(cout_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bsa_lane u_lane (
      .a_bit(sense_a[g]), .b_bit(sense_b[g]), .c_bit(sense_c[g]),
      .sub(op_q), .s_bit(sum_now[g]), .c_out(cout_now[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= '0;
    end else if (sense_en) begin
      sum_q  <= sum_now;
      cout_q <= cout_now;
    end
  end
endmodule

// File: rtl/bsa_chk.sv
module bsa_chk #(
  parameter int LANES = 8,
  parameter int WMAX  = 8,
  parameter int WW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WW-1:0]    width,
  input logic             busy,
  input logic [LANES-1:0] mem_rdata
);
  logic          take;
  logic [WW-1:0] w_lat;
  logic [WW:0]   span;

  assign take = start && !busy && (width != '0) && (width <= WW'(WMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_lat <= '0;
      span  <= '0;
    end else if (take) begin
      w_lat <= width;
      span  <= '0;
    end else if (busy) begin
      span <= span + 1'b1;
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy); // R3
  AST_BAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && ((width == '0) || (width > WW'(WMAX))) |=> !busy); // R8
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (span == {w_lat, 1'b0})); // R3
  AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (span < {w_lat, 1'b0})); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mem_rdata)); // R6
endmodule

bind bsa_engine bsa_chk #(.LANES(LANES), .WMAX(WMAX), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .width(width),
  .busy(busy), .mem_rdata(mem_rdata)
);

// File: tb/bsa_engine_tb.sv
module bsa_engine_tb;
  localparam int LANES = 8;
  localparam int ROWS  = 32;
  localparam int WMAX  = 8;
  localparam int AW    = $clog2(ROWS);
  localparam int WW    = $clog2(WMAX + 1);
  localparam int A0 = 0, B0 = 8, R0 = 16, PROBE = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_sub = 1'b0;
  logic [AW-1:0] a_base = AW'(A0), b_base = AW'(B0), r_base = AW'(R0);
  logic [WW-1:0] width = '0;
  logic busy;
  logic mem_en = 1'b0, mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [LANES-1:0] mem_wdata = '0;
  logic [LANES-1:0] mem_rdata;

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;
  int av [LANES];
  int bv [LANES];

  always #2 clk = ~clk;

  bsa_engine #(.LANES(LANES), .ROWS(ROWS), .WMAX(WMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a_base(a_base), .b_base(b_base), .r_base(r_base), .width(width),
    .busy(busy), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic host_write(int row, logic [LANES-1:0] d);
    @(negedge clk);
    mem_en = 1'b1; mem_we = 1'b1; mem_addr = AW'(row); mem_wdata = d;
    @(negedge clk);
    mem_en = 1'b0; mem_we = 1'b0;
  endtask

  task automatic host_read(int row, output logic [LANES-1:0] d);
    @(negedge clk);
    mem_en = 1'b1; mem_we = 1'b0; mem_addr = AW'(row);
    @(negedge clk);
    d = mem_rdata;
    mem_en = 1'b0;
  endtask

  // poke: disturb the engine while busy (second start, host write/read)
  task automatic run_op(bit sub, int w, bit poke);
    logic [LANES-1:0] row, held;
    int cnt, mask, exp, got;
    for (int i = 0; i < w; i++) begin
      for (int l = 0; l < LANES; l++) row[l] = av[l][i];
      host_write(A0 + i, row);
      for (int l = 0; l < LANES; l++) row[l] = bv[l][i];
      host_write(B0 + i, row);
    end
    @(negedge clk);
    start = 1'b1; op_sub = sub; width = WW'(w);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    held = mem_rdata;
    while (busy && cnt < 64) begin
      if (poke) begin
        if (cnt == 0) begin
          start = 1'b1; op_sub = ~sub; width = WW'(WMAX);
          mem_en = 1'b1; mem_we = 1'b1; mem_addr = AW'(PROBE); mem_wdata = 8'hFF;
        end else if (cnt == 1) begin
          start = 1'b0; mem_we = 1'b0; mem_addr = AW'(PROBE);
        end else if (cnt == 2) begin
          mem_en = 1'b0;
        end else if (cnt == 3) begin
          chk("R6 rdata held while busy", int'(mem_rdata), int'(held));
        end
      end
      cnt++;
      @(negedge clk);
    end
    chk(poke ? "R7 busy span after ignored start" : "R3 busy span", cnt, 2 * w);
    mask = (1 << (w + 1)) - 1;
    for (int l = 0; l < LANES; l++) begin
      got = 0;
      av[l] = av[l];
    end
    begin
      int res [LANES];
      for (int l = 0; l < LANES; l++) res[l] = 0;
      for (int i = 0; i <= w; i++) begin
        host_read(R0 + i, row);
        for (int l = 0; l < LANES; l++) res[l] |= int'(row[l]) << i;
      end
      for (int l = 0; l < LANES; l++) begin
        exp = sub ? ((av[l] - bv[l]) & mask) : ((av[l] + bv[l]) & mask);
        chk(sub ? "R2 lane difference" : "R1 lane sum", res[l], exp);
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [LANES-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset busy", int'(busy), 0);
    chk("R5 reset rdata", int'(mem_rdata), 0);

    host_write(PROBE, 8'h5A);
    host_read(PROBE, d);
    chk("R5 write then read", int'(d), 'h5A);

    // R8: illegal widths
    @(negedge clk); start = 1'b1; width = '0;
    @(negedge clk); start = 1'b0;
    chk("R8 width 0 ignored", int'(busy), 0);
    @(negedge clk); start = 1'b1; width = WW'(WMAX + 1);
    @(negedge clk); start = 1'b0;
    chk("R8 width over max ignored", int'(busy), 0);

    // R1/R2/R9: exhaustive sweep over widths 1..4, lanes hold distinct pairs
    for (int w = 1; w <= 4; w++) begin
      int pairs = 1 << (2 * w);
      int runs = (pairs + LANES - 1) / LANES;
      for (int s = 0; s < 2; s++) begin
        for (int r = 0; r < runs; r++) begin
          for (int l = 0; l < LANES; l++) begin
            int k = (r * LANES + l) % pairs;
            av[l] = k & ((1 << w) - 1);
            bv[l] = k >> w;
          end
          run_op(s[0], w, 1'b0);
        end
      end
    end

    // wider operands with pseudo-random lanes
    for (int w = 5; w <= WMAX; w++) begin
      for (int r = 0; r < 6; r++) begin
        for (int l = 0; l < LANES; l++) begin
          av[l] = int'($urandom % (1 << w));
          bv[l] = int'($urandom % (1 << w));
        end
        run_op(r[0], w, 1'b0);
      end
    end

    // R4: an all-carry add leaves the carry row at 1; a following sub must start clean
    for (int l = 0; l < LANES; l++) begin av[l] = 15; bv[l] = 15; end
    run_op(1'b0, 4, 1'b0);
    for (int l = 0; l < LANES; l++) begin av[l] = l; bv[l] = l; end
    run_op(1'b1, 4, 1'b0);
    for (int l = 0; l < LANES; l++) begin av[l] = 3; bv[l] = 0; end
    run_op(1'b0, 3, 1'b0);
    host_read(R0 + 3, d);
    chk("R4 no stale carry in top row", int'(d), 0);

    // R6/R7: second start, host write and host read during a command
    for (int l = 0; l < LANES; l++) begin av[l] = 7 - l; bv[l] = l; end
    run_op(1'b1, 3, 1'b1);
    host_read(PROBE, d);
    chk("R6 write while busy ignored", int'(d), 'h5A);

    summary();
  end
endmodule